// File: doc/BRIEF.md
# USB Host Interrupt Status Aggregator

This block gathers every interrupt condition of a USB host controller into one read-only 32-bit status word and one interrupt request line. The host engine delivers single-cycle event pulses: start of frame or low-speed keep-alive sent, upstream resume received, downstream resume sent, bus reset sent, device connect and device disconnect. The block latches each pulse into a flag that stays up until software writes a one to its clear bit. The pipes and the DMA channels deliver interrupt levels, and the status word mirrors these directly. They drop when their own sources are served.

A wake-up flag is raised when the port is suspended (SOF generation off) and a resume or a disconnect is seen, or when the controller sits idle with no VBus requested. The wake-up condition reaches a capture flop through an asynchronous set. This lets it register even while the clock-freeze control stops the ordinary flags. A two-stage synchronizer then carries it to the status word.

The interrupt request is the OR of all status bits that have their enable bit set. The clear strobe and the enable word come from a register port elsewhere in the controller.

Top module: `uhost_irq_agg`

## Requirements
- R1: A synchronous active-high reset clears the whole status word to zero, provided no wake-up condition is present during reset.
- R2: The status bit positions are fixed: 31:25 DMA channels 7..1, 15:8 pipes 7..0, 6 wake-up, 5 SOF, 4 resume received, 3 resume sent, 2 reset sent, 1 disconnect, 0 connect. Bits 24:16 and bit 7 always read zero.
- R3: Status bits 31:25 follow `dma_irq[6:0]` in the same cycle, with `dma_irq[k]` shown at bit 25+k.
- R4: Status bits 15:8 follow `pipe_irq[7:0]` in the same cycle.
- R5: The wake-up condition is (`sof_en`=0 and (`ev_rsm_rx` or `ev_disc`)) or (`idle_st`=1 and `vbus_req`=0). When it is present in the cycle before clock edge E, bit 6 reads one after edge E+1. The bit stays set until a write with `clr_data[6]`=1 is made while the condition is absent.
- R6: The wake-up bit sets even while `frz_clk` is high.
- R7: Bit 5 sets after the edge at which `ev_sof` is high, or at which `ev_keepalive` is high while `low_speed` is 1. A keep-alive with `low_speed`=0 does not set it.
- R8: Bits 5:0 are write-one-to-clear. When `clr_wr`=1, each `clr_data[i]`=1 clears bit i at the next edge. A zero in `clr_data` leaves its bit unchanged.
- R9: When a set event and a write-one clear reach the same event flag at the same edge, the flag ends up set.
- R10: While `frz_clk` is high, bits 5:0 hold their value. Event pulses and clears in that cycle have no effect.
- R11: `irq` is one exactly when some status bit and the same bit of `irq_en` are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| frz_clk | input | 1 | Clock-freeze control; holds the event flags |
| sof_en | input | 1 | SOF generation enabled; 0 means suspended |
| idle_st | input | 1 | Host controller in idle state |
| vbus_req | input | 1 | VBus generation requested |
| low_speed | input | 1 | Port runs at low speed |
| ev_sof | input | 1 | Pulse: start of frame issued |
| ev_keepalive | input | 1 | Pulse: keep-alive sent |
| ev_rsm_rx | input | 1 | Pulse: upstream resume received |
| ev_rsm_tx | input | 1 | Pulse: downstream resume sent |
| ev_rst_sent | input | 1 | Pulse: bus reset sent |
| ev_conn | input | 1 | Pulse: device connected |
| ev_disc | input | 1 | Pulse: device disconnected |
| pipe_irq | input | NUM_PIPES | Per-pipe interrupt levels |
| dma_irq | input | NUM_DMA | Per-DMA-channel interrupt levels, channel 1 at index 0 |
| clr_wr | input | 1 | Clear word write strobe |
| clr_data | input | 7 | Clear word, bit i clears status bit i |
| irq_en | input | 32 | Interrupt enable word, bit-aligned to status |
| status | output | 32 | Interrupt status word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong event flag shows in the status word one edge after the pulse or clear that should have changed it. For this reason the reference model is compared field by field at every falling edge. A fault in the wake-up path shows two edges late, so the suspend, idle and frozen cases are each run long enough to pass through both synchronizer stages. Mirror and interrupt faults show in the same cycle. A missed set-over-clear or freeze hold shows as a bit that reads zero one cycle too early.

// File: rtl/uhost_irq_pkg.sv
package uhost_irq_pkg;

    localparam int STATUS_W         = 32;
    localparam int EVT_W            = 6;
    localparam int CLR_W            = EVT_W + 1;
    localparam int WAKE_BIT         = 6;
    localparam int PIPE_LSB         = 8;
    localparam int PIPE_MAX         = 8;
    localparam int DMA_LSB          = 25;
    localparam int DMA_MAX          = 7;
    localparam int RSVD_HI_W        = DMA_LSB - PIPE_LSB - PIPE_MAX;
    localparam int WAKE_SYNC_STAGES = 2;

    // Field order matches status bits 5 down to 0.
    typedef struct packed {
        logic sof;
        logic rsm_rx;
        logic rsm_tx;
        logic rst_sent;
        logic disc;
        logic conn;
    } evt_t;

    typedef struct packed {
        logic [DMA_MAX-1:0]   dma;
        logic [RSVD_HI_W-1:0] rsvd_hi;
        logic [PIPE_MAX-1:0]  pipe;
        logic                 rsvd_lo;
        logic                 wake;
        evt_t                 evt;
    } status_t;

    function automatic status_t build_status(
        input evt_t                e,
        input logic                w,
        input logic [PIPE_MAX-1:0] p,
        input logic [DMA_MAX-1:0]  d
    );
        status_t s;
        s.dma     = d;
        s.rsvd_hi = '0;
        s.pipe    = p;
        s.rsvd_lo = 1'b0;
        s.wake    = w;
        s.evt     = e;
        return s;
    endfunction

    function automatic logic wake_condition(
        input logic sof_on,
        input logic resume_seen,
        input logic disc_seen,
        input logic idle,
        input logic vbus_on
    );
        return (!sof_on && (resume_seen || disc_seen)) || (idle && !vbus_on);
    endfunction

endpackage

// File: rtl/uhost_irq_evt_flags.sv
module uhost_irq_evt_flags
    import uhost_irq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] flags
);

    for (genvar i = 0; i < W; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (!hold) begin
                if (set_v[i]) begin
                    q <= 1'b1;
                end else if (clr_v[i]) begin
                    q <= 1'b0;
                end
            end
        end
        assign flags[i] = q;
    end

endmodule

// File: rtl/uhost_irq_wake_catch.sv
module uhost_irq_wake_catch
    import uhost_irq_pkg::*;
#(
    parameter int STAGES = WAKE_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_req,
    input  logic clr,
    output logic wake_o
);

    logic              cap_q;
    logic [STAGES-1:0] sync_q;

    // Asynchronous set so the condition is held even with no clock activity.
    always_ff @(posedge clk or posedge wake_req) begin
        if (wake_req) begin
            cap_q <= 1'b1;
        end else if (rst) begin
            cap_q <= 1'b0;
        end else if (clr) begin
            cap_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], cap_q};
        end
    end

    assign wake_o = sync_q[STAGES-1];

endmodule

// File: rtl/uhost_irq_merge.sv
module uhost_irq_merge
    import uhost_irq_pkg::*;
#(
    parameter int NUM_PIPES = PIPE_MAX,
    parameter int NUM_DMA   = DMA_MAX
) (
    input  evt_t                 evt,
    input  logic                 wake,
    input  logic [NUM_PIPES-1:0] pipe_lvl,
    input  logic [NUM_DMA-1:0]   dma_lvl,
    input  logic [STATUS_W-1:0]  en,
    output logic [STATUS_W-1:0]  status,
    output logic                 irq
);

    logic [PIPE_MAX-1:0] pipe_ext;
    logic [DMA_MAX-1:0]  dma_ext;
    status_t             word;
    logic [STATUS_W-1:0] pend;

    always_comb begin
        pipe_ext                = '0;
        pipe_ext[NUM_PIPES-1:0] = pipe_lvl;
        dma_ext                 = '0;
        dma_ext[NUM_DMA-1:0]    = dma_lvl;
    end

    always_comb begin
        word = build_status(evt, wake, pipe_ext, dma_ext);
    end

    assign status = word;
    assign pend   = status & en;
    assign irq    = |pend;

endmodule

// File: rtl/uhost_irq_agg.sv
module uhost_irq_agg
    import uhost_irq_pkg::*;
#(
    parameter int NUM_PIPES = PIPE_MAX,
    parameter int NUM_DMA   = DMA_MAX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frz_clk,
    input  logic                 sof_en,
    input  logic                 idle_st,
    input  logic                 vbus_req,
    input  logic                 low_speed,
    input  logic                 ev_sof,
    input  logic                 ev_keepalive,
    input  logic                 ev_rsm_rx,
    input  logic                 ev_rsm_tx,
    input  logic                 ev_rst_sent,
    input  logic                 ev_conn,
    input  logic                 ev_disc,
    input  logic [NUM_PIPES-1:0] pipe_irq,
    input  logic [NUM_DMA-1:0]   dma_irq,
    input  logic                 clr_wr,
    input  logic [CLR_W-1:0]     clr_data,
    input  logic [STATUS_W-1:0]  irq_en,
    output logic [STATUS_W-1:0]  status,
    output logic                 irq
);

    evt_t             set_e;
    logic [EVT_W-1:0] clr_v;
    logic [EVT_W-1:0] flag_v;
    evt_t             flag_e;
    logic             wake_req;
    logic             wake_clr;
    logic             wake_s;

    always_comb begin
        set_e.sof      = ev_sof | (low_speed & ev_keepalive);
        set_e.rsm_rx   = ev_rsm_rx;
        set_e.rsm_tx   = ev_rsm_tx;
        set_e.rst_sent = ev_rst_sent;
        set_e.disc     = ev_disc;
        set_e.conn     = ev_conn;
    end

    assign clr_v    = {EVT_W{clr_wr}} & clr_data[EVT_W-1:0];
    assign wake_req = wake_condition(sof_en, ev_rsm_rx, ev_disc, idle_st, vbus_req);
    assign wake_clr = clr_wr & clr_data[WAKE_BIT];

    uhost_irq_evt_flags #(
        .W(EVT_W)
    ) u_flags (
        .clk  (clk),
        .rst  (rst),
        .hold (frz_clk),
        .set_v(set_e),
        .clr_v(clr_v),
        .flags(flag_v)
    );

    assign flag_e = evt_t'(flag_v);

    uhost_irq_wake_catch #(
        .STAGES(WAKE_SYNC_STAGES)
    ) u_wake (
        .clk     (clk),
        .rst     (rst),
        .wake_req(wake_req),
        .clr     (wake_clr),
        .wake_o  (wake_s)
    );

    uhost_irq_merge #(
        .NUM_PIPES(NUM_PIPES),
        .NUM_DMA  (NUM_DMA)
    ) u_merge (
        .evt     (flag_e),
        .wake    (wake_s),
        .pipe_lvl(pipe_irq),
        .dma_lvl (dma_irq),
        .en      (irq_en),
        .status  (status),
        .irq     (irq)
    );

endmodule

// File: rtl/uhost_irq_agg_chk.sv
module uhost_irq_agg_chk
    import uhost_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frz_clk,
    input logic                sof_en,
    input logic                idle_st,
    input logic                vbus_req,
    input logic                low_speed,
    input logic                ev_sof,
    input logic                ev_keepalive,
    input logic                ev_rsm_rx,
    input logic                ev_rsm_tx,
    input logic                ev_rst_sent,
    input logic                ev_conn,
    input logic                pipe0,
    input logic                dma0,
    input logic                clr_wr,
    input logic                clr2,
    input logic                clr3,
    input logic [STATUS_W-1:0] irq_en,
    input logic [STATUS_W-1:0] status,
    input logic                irq
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (status[24:16] == 9'd0) && !status[7]);

    p_dma_mirror_r3: assert property (@(posedge clk) disable iff (rst)
        dma0 |-> status[DMA_LSB]);

    p_pipe_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pipe0) |-> status[PIPE_LSB]);

    p_wake_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (!sof_en && ev_rsm_rx) |=> ##1 status[WAKE_BIT]);

    p_wake_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (frz_clk && idle_st && !vbus_req) |=> ##1 status[WAKE_BIT]);

    p_sof_set_r7: assert property (@(posedge clk) disable iff (rst)
        (!frz_clk && (ev_sof || (low_speed && ev_keepalive))) |=> status[5]);

    p_conn_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!frz_clk && ev_conn) |=> status[0]);

    p_w1c_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!frz_clk && clr_wr && clr3 && !ev_rsm_tx) |=> !status[3]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (!frz_clk && clr_wr && clr2 && ev_rst_sent) |=> status[2]);

    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
        frz_clk |=> $stable(status[5:0]));

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !irq |-> ((status & irq_en) == '0));

endmodule

bind uhost_irq_agg uhost_irq_agg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frz_clk     (frz_clk),
    .sof_en      (sof_en),
    .idle_st     (idle_st),
    .vbus_req    (vbus_req),
    .low_speed   (low_speed),
    .ev_sof      (ev_sof),
    .ev_keepalive(ev_keepalive),
    .ev_rsm_rx   (ev_rsm_rx),
    .ev_rsm_tx   (ev_rsm_tx),
    .ev_rst_sent (ev_rst_sent),
    .ev_conn     (ev_conn),
    .pipe0       (pipe_irq[0]),
    .dma0        (dma_irq[0]),
    .clr_wr      (clr_wr),
    .clr2        (clr_data[2]),
    .clr3        (clr_data[3]),
    .irq_en      (irq_en),
    .status      (status),
    .irq         (irq)
);

// File: tb/uhost_irq_agg_test.sv
`timescale 1ns/100ps
module uhost_irq_agg_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frz_clk = 1'b0;
    logic        sof_en = 1'b1;
    logic        idle_st = 1'b0;
    logic        vbus_req = 1'b1;
    logic        low_speed = 1'b0;
    logic        ev_sof = 1'b0;
    logic        ev_keepalive = 1'b0;
    logic        ev_rsm_rx = 1'b0;
    logic        ev_rsm_tx = 1'b0;
    logic        ev_rst_sent = 1'b0;
    logic        ev_conn = 1'b0;
    logic        ev_disc = 1'b0;
    logic [7:0]  pipe_irq = 8'h00;
    logic [6:0]  dma_irq = 7'h00;
    logic        clr_wr = 1'b0;
    logic [6:0]  clr_data = 7'h00;
    logic [31:0] irq_en = 32'h0;
    logic [31:0] status;
    logic        irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    uhost_irq_agg uut (
        .clk(clk), .rst(rst), .frz_clk(frz_clk), .sof_en(sof_en),
        .idle_st(idle_st), .vbus_req(vbus_req), .low_speed(low_speed),
        .ev_sof(ev_sof), .ev_keepalive(ev_keepalive), .ev_rsm_rx(ev_rsm_rx),
        .ev_rsm_tx(ev_rsm_tx), .ev_rst_sent(ev_rst_sent), .ev_conn(ev_conn),
        .ev_disc(ev_disc), .pipe_irq(pipe_irq), .dma_irq(dma_irq),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    // Reference model, built from the requirements only.
    logic [5:0] m_evt = 6'h0;
    logic       m_cap = 1'b0;
    logic       m_s1 = 1'b0;
    logic       m_s2 = 1'b0;
    bit         m_rst_seen = 1'b0;
    logic       wreq;
    logic [5:0] setv;

    assign wreq = (!sof_en && (ev_rsm_rx || ev_disc)) || (idle_st && !vbus_req);
    assign setv = {ev_sof | (low_speed & ev_keepalive), ev_rsm_rx, ev_rsm_tx,
                   ev_rst_sent, ev_disc, ev_conn};

    always @(posedge clk) begin
        m_rst_seen = rst;
        if (rst) begin
            m_evt = 6'h0;
            m_s1  = 1'b0;
            m_s2  = 1'b0;
            m_cap = wreq;
        end else begin
            m_s2 = m_s1;
            m_s1 = m_cap | wreq;
            if (!frz_clk) begin
                for (int i = 0; i < 6; i++) begin
                    if (setv[i]) m_evt[i] = 1'b1;
                    else if (clr_wr && clr_data[i]) m_evt[i] = 1'b0;
                end
            end
            if (wreq) m_cap = 1'b1;
            else if (clr_wr && clr_data[6]) m_cap = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] e;
        e = 32'h0;
        e[31:25] = dma_irq;
        e[15:8]  = pipe_irq;
        e[6]     = m_s2;
        e[5:0]   = m_evt;
        if (m_rst_seen) begin
            chk("R1 reset word", status, e);
        end
        chk("R3 dma field", status & 32'hFE00_0000, e & 32'hFE00_0000);
        chk("R4 pipe field", status & 32'h0000_FF00, e & 32'h0000_FF00);
        chk("R2 reserved bits", status & 32'h01FF_0080, 32'h0);
        chk("R5 wake bit", {31'h0, status[6]}, {31'h0, e[6]});
        chk("R7 sof bit", {31'h0, status[5]}, {31'h0, e[5]});
        chk("R8 event bits", {27'h0, status[4:0]}, {27'h0, e[4:0]});
        chk("R11 irq", {31'h0, irq}, {31'h0, |(e & irq_en)});
    end

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic idle_inputs();
        ev_sof = 0; ev_keepalive = 0; ev_rsm_rx = 0; ev_rsm_tx = 0;
        ev_rst_sent = 0; ev_conn = 0; ev_disc = 0; clr_wr = 0; clr_data = 7'h0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1 status after reset", status, 32'h0);
        rst = 0;
        step();

        // Each event type sets its own flag (R7, R8).
        ev_sof = 1; step(); idle_inputs();
        chk("R7 sof pulse", status, 32'h0000_0020);
        ev_rsm_rx = 1; step(); idle_inputs();
        ev_rsm_tx = 1; step(); idle_inputs();
        ev_rst_sent = 1; step(); idle_inputs();
        ev_conn = 1; step(); idle_inputs();
        ev_disc = 1; step(); idle_inputs();
        chk("R8 all event flags", status, 32'h0000_003F);
        step(); step();
        chk("R5 no wake while running", {31'h0, status[6]}, 32'h0);

        // Enable masking (R11).
        irq_en = 32'h0000_0010; step();
        chk("R11 irq with one enable", {31'h0, irq}, 32'h1);
        irq_en = 32'hFFFF_FFC0; step();
        chk("R11 irq masked", {31'h0, irq}, 32'h0);

        // Zero writes leave flags, one writes clear them (R8).
        clr_wr = 1; clr_data = 7'h00; step(); idle_inputs();
        chk("R8 zero clear no effect", status, 32'h0000_003F);
        clr_wr = 1; clr_data = 7'h20; step(); idle_inputs();
        chk("R8 clear sof", status, 32'h0000_001F);
        clr_wr = 1; clr_data = 7'h7F; step(); idle_inputs();
        chk("R8 clear all", status, 32'h0);

        // Keep-alive only counts at low speed (R7).
        ev_keepalive = 1; step(); idle_inputs();
        chk("R7 keepalive full speed", status, 32'h0);
        low_speed = 1; ev_keepalive = 1; step(); idle_inputs();
        chk("R7 keepalive low speed", status, 32'h0000_0020);
        low_speed = 0;

        // Set beats clear (R9).
        ev_rst_sent = 1; clr_wr = 1; clr_data = 7'h04; step(); idle_inputs();
        chk("R9 set wins over clear", {31'h0, status[2]}, 32'h1);
        ev_rsm_tx = 1; step(); idle_inputs();

        // Freeze holds event flags (R10).
        frz_clk = 1;
        clr_wr = 1; clr_data = 7'h3F; ev_conn = 1; step(); idle_inputs();
        chk("R10 frozen flags hold", {26'h0, status[5:0]}, 32'h0000_002C);
        frz_clk = 0; step();

        // Wake via resume in suspend (R5).
        clr_wr = 1; clr_data = 7'h7F; step(); idle_inputs();
        sof_en = 0; ev_rsm_rx = 1; step(); idle_inputs();
        chk("R5 wake one edge in", {31'h0, status[6]}, 32'h0);
        step();
        chk("R5 wake after sync", {31'h0, status[6]}, 32'h1);
        clr_wr = 1; clr_data = 7'h40; step(); idle_inputs();
        step(); step();
        chk("R5 wake cleared", {31'h0, status[6]}, 32'h0);
        ev_disc = 1; step(); idle_inputs(); step();
        chk("R5 wake on disconnect", {31'h0, status[6]}, 32'h1);
        sof_en = 1;
        clr_wr = 1; clr_data = 7'h7F; step(); idle_inputs(); step(); step();

        // Wake while frozen, idle with no VBus (R6).
        frz_clk = 1; idle_st = 1; vbus_req = 0; step(); step();
        chk("R6 wake during freeze", {31'h0, status[6]}, 32'h1);
        clr_wr = 1; clr_data = 7'h40; step(); idle_inputs(); step(); step();
        chk("R5 clear ignored while condition held", {31'h0, status[6]}, 32'h1);
        frz_clk = 0; idle_st = 0; vbus_req = 1; step();
        clr_wr = 1; clr_data = 7'h40; step(); idle_inputs(); step(); step();

        // Level mirrors (R3, R4).
        pipe_irq = 8'hA5; dma_irq = 7'h41; step();
        chk("R4 pipe mirror", status & 32'h0000_FF00, 32'h0000_A500);
        chk("R3 dma mirror", status & 32'hFE00_0000, 32'h8200_0000);
        irq_en = 32'h0000_0100; step();
        chk("R11 pipe irq", {31'h0, irq}, 32'h1);
        pipe_irq = 8'h00; step();
        chk("R11 pipe source served", {31'h0, irq}, 32'h0);

        // Randomised traffic checked against the model each cycle.
        for (int n = 0; n < 600; n++) begin
            step();
            idle_inputs();
            ev_sof       = ($urandom % 5) == 0;
            ev_keepalive = ($urandom % 5) == 0;
            ev_rsm_rx    = ($urandom % 9) == 0;
            ev_rsm_tx    = ($urandom % 7) == 0;
            ev_rst_sent  = ($urandom % 7) == 0;
            ev_conn      = ($urandom % 8) == 0;
            ev_disc      = ($urandom % 8) == 0;
            clr_wr       = ($urandom % 3) == 0;
            clr_data     = 7'($urandom);
            frz_clk      = ($urandom % 8) == 0;
            sof_en       = ($urandom % 4) != 0;
            idle_st      = ($urandom % 10) == 0;
            vbus_req     = ($urandom % 3) != 0;
            low_speed    = ($urandom % 2) == 0;
            pipe_irq     = 8'($urandom);
            dma_irq      = 7'($urandom);
            irq_en       = $urandom;
        end

        // Reset in mid-run with no wake condition (R1).
        step(); idle_inputs();
        sof_en = 1; idle_st = 0; vbus_req = 1; frz_clk = 0;
        pipe_irq = 8'h00; dma_irq = 7'h00;
        rst = 1; step(); step();
        chk("R1 mid-run reset", status, 32'h0);
        rst = 0; step(); step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule